// File: doc/BRIEF.md
# Three-Port Parallel I/O Register Block

This block is the register file that a CPU uses to drive three 7-bit parallel controller ports, called A, B and C. It decodes a 4-bit byte offset on a simple byte-wide bus. Each port has four registers: a data latch, a direction mask, a transmit byte and a serial-control byte. The direction mask decides, bit by bit, which pins the port drives. When the CPU reads a data latch, it gets a merged value: driven bits come from the latch and undriven bits come from the live pin levels.

Peripheral models or pad logic next to the block follow the ports through two buses per port, a drive value and a drive enable. They also see a one-cycle update strobe. The strobe carries the port index, the data byte and the direction byte. A strobe follows every data write. A direction write raises the strobe only when the written value differs from the stored one. Offset 0x00 is a read-only version byte built from parameters. The low three bits of each serial-control register show live status inputs. No serial shifting engine is included.

Top module: `pario_regs`

## Requirements
- R1: Out of reset, every register reads 0x00 with these exceptions. Offsets 0x07 and 0x0A read 0xFF. Offset 0x0D reads 0xFB. Offset 0x00 reads the version byte.
- R2: `out_val_x` equals bits 6..0 of that port's data latch (offsets 0x01/0x02/0x03 for A/B/C). `out_en_x` equals bits 6..0 of its direction register (offsets 0x04/0x05/0x06). A 1 in the direction register means the pin is driven.
- R3: A read of a data offset returns, for each bit, the stored latch bit where (0x80 | direction) has a 1 and the pin input where it has a 0. Bit 7 therefore always comes from the latch, and the pin bus supplies bits 6..0.
- R4: A write to a data offset stores the byte. In the next cycle `upd_valid` is high for exactly that cycle, with `upd_port` set to the port index (0=A, 1=B, 2=C), `upd_data` set to the written byte and `upd_ctrl` set to the port's direction byte.
- R5: A write to a direction offset stores the byte. It raises `upd_valid` in the next cycle only if the byte differs from the stored value; that strobe carries the port's data latch and the new direction byte. No strobe follows a cycle without a data write or a changing direction write.
- R6: The transmit registers at offsets 0x07, 0x0A and 0x0D (A, B, C) store and read back the full byte.
- R7: A write to a serial-control offset (0x09, 0x0C, 0x0F for A, B, C) stores only bits 7..3. A read returns those stored bits with the port's `ser_stat_x` input in bits 2..0. Bits 7..6 hold the rate code: 00=4800, 01=2400, 10=1200, 11=300 bit/s.
- R8: Offset 0x00 reads REGION_CODE OR'd with BIOS_PRESENT in bit 0, and with bit 5 set when DISC_ATTACHED is 0. Writes to it change nothing.
- R9: Offsets 0x08, 0x0B and 0x0E read 0x00, and writes to them change nothing.
- R10: A read returns its value combinationally in the cycle of the strobe, and a read changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pin_in_a | input | 7 | Port A pin levels |
| pin_in_b | input | 7 | Port B pin levels |
| pin_in_c | input | 7 | Port C pin levels |
| ser_stat_a | input | 3 | Port A serial status bits |
| ser_stat_b | input | 3 | Port B serial status bits |
| ser_stat_c | input | 3 | Port C serial status bits |
| out_val_a | output | 7 | Port A drive values |
| out_val_b | output | 7 | Port B drive values |
| out_val_c | output | 7 | Port C drive values |
| out_en_a | output | 7 | Port A drive enables |
| out_en_b | output | 7 | Port B drive enables |
| out_en_c | output | 7 | Port C drive enables |
| upd_valid | output | 1 | One-cycle port update strobe |
| upd_port | output | 2 | Port index of the update |
| upd_data | output | 8 | Data byte of the update |
| upd_ctrl | output | 8 | Direction byte of the update |

## Verification
A bad latch or direction byte shows at once on the drive buses. It also shows on the very next read of that port, either as a stored bit where a pin level belongs or as a pin level where a stored bit belongs. A bad comparison in the direction-write path shows one cycle after the write, as a missing or extra update strobe. The bench therefore compares every output against a behavioural model on every cycle. It drives random pins and random accesses, and it repeats direction writes with unchanged values, so a stale register cannot hide for more than one cycle.

// File: rtl/pario_regs.sv
`timescale 1ns/1ps
module pario_regs #(
  parameter logic [7:0] REGION_CODE   = 8'h80,
  parameter bit         BIOS_PRESENT  = 1'b0,
  parameter bit         DISC_ATTACHED = 1'b0,
  parameter int         PIN_W         = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [3:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [PIN_W-1:0] pin_in_a,
  input  logic [PIN_W-1:0] pin_in_b,
  input  logic [PIN_W-1:0] pin_in_c,
  input  logic [2:0]       ser_stat_a,
  input  logic [2:0]       ser_stat_b,
  input  logic [2:0]       ser_stat_c,
  output logic [PIN_W-1:0] out_val_a,
  output logic [PIN_W-1:0] out_val_b,
  output logic [PIN_W-1:0] out_val_c,
  output logic [PIN_W-1:0] out_en_a,
  output logic [PIN_W-1:0] out_en_b,
  output logic [PIN_W-1:0] out_en_c,
  output logic             upd_valid,
  output logic [1:0]       upd_port,
  output logic [7:0]       upd_data,
  output logic [7:0]       upd_ctrl
);
  localparam int NPORT = 3;
  localparam logic [7:0] VERSION = REGION_CODE | (DISC_ATTACHED ? 8'h00 : 8'h20)
                                   | {7'd0, BIOS_PRESENT};
  localparam logic [7:0] SCTL_KEEP = 8'hF8;

  logic [7:0] dat [NPORT];
  logic [7:0] ctl [NPORT];
  logic [7:0] txd [NPORT];
  logic [7:0] sct [NPORT];
  logic [2:0] stat [NPORT];
  logic [7:0] pins [NPORT];

  assign stat[0] = ser_stat_a;
  assign stat[1] = ser_stat_b;
  assign stat[2] = ser_stat_c;
  assign pins[0] = {{(8-PIN_W){1'b0}}, pin_in_a};
  assign pins[1] = {{(8-PIN_W){1'b0}}, pin_in_b};
  assign pins[2] = {{(8-PIN_W){1'b0}}, pin_in_c};

  typedef enum logic [2:0] {K_NONE, K_VER, K_DAT, K_CTL, K_TXD, K_SCT} kind_t;
  kind_t      kind;
  logic [1:0] idx;

  always_comb begin
    kind = K_NONE;
    idx  = 2'd0;
    case (bus_addr)
      4'h0: kind = K_VER;
      4'h1: begin kind = K_DAT; idx = 2'd0; end
      4'h2: begin kind = K_DAT; idx = 2'd1; end
      4'h3: begin kind = K_DAT; idx = 2'd2; end
      4'h4: begin kind = K_CTL; idx = 2'd0; end
      4'h5: begin kind = K_CTL; idx = 2'd1; end
      4'h6: begin kind = K_CTL; idx = 2'd2; end
      4'h7: begin kind = K_TXD; idx = 2'd0; end
      4'hA: begin kind = K_TXD; idx = 2'd1; end
      4'hD: begin kind = K_TXD; idx = 2'd2; end
      4'h9: begin kind = K_SCT; idx = 2'd0; end
      4'hC: begin kind = K_SCT; idx = 2'd1; end
      4'hF: begin kind = K_SCT; idx = 2'd2; end
      default: kind = K_NONE;
    endcase
  end

  wire wr = bus_sel & bus_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPORT; i++) begin
        dat[i] <= 8'h00;
        ctl[i] <= 8'h00;
        sct[i] <= 8'h00;
      end
      txd[0] <= 8'hFF;
      txd[1] <= 8'hFF;
      txd[2] <= 8'hFB;
    end else if (wr) begin
      case (kind)
        K_DAT: dat[idx] <= bus_wdata;
        K_CTL: ctl[idx] <= bus_wdata;
        K_TXD: txd[idx] <= bus_wdata;
        K_SCT: sct[idx] <= bus_wdata & SCTL_KEEP;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_valid <= 1'b0;
      upd_port  <= 2'd0;
      upd_data  <= 8'h00;
      upd_ctrl  <= 8'h00;
    end else begin
      upd_valid <= 1'b0;
      if (wr && kind == K_DAT) begin
        upd_valid <= 1'b1;
        upd_port  <= idx;
        upd_data  <= bus_wdata;
        upd_ctrl  <= ctl[idx];
      end else if (wr && kind == K_CTL && bus_wdata != ctl[idx]) begin
        upd_valid <= 1'b1;
        upd_port  <= idx;
        upd_data  <= dat[idx];
        upd_ctrl  <= bus_wdata;
      end
    end
  end

  logic [7:0] rmask;
  assign rmask = 8'h80 | ctl[idx];

  always_comb begin
    case (kind)
      K_VER:   bus_rdata = VERSION;
      K_DAT:   bus_rdata = (dat[idx] & rmask) | (pins[idx] & ~rmask);
      K_CTL:   bus_rdata = ctl[idx];
      K_TXD:   bus_rdata = txd[idx];
      K_SCT:   bus_rdata = sct[idx] | {5'd0, stat[idx]};
      default: bus_rdata = 8'h00;
    endcase
  end

  assign out_val_a = dat[0][PIN_W-1:0];
  assign out_val_b = dat[1][PIN_W-1:0];
  assign out_val_c = dat[2][PIN_W-1:0];
  assign out_en_a  = ctl[0][PIN_W-1:0];
  assign out_en_b  = ctl[1][PIN_W-1:0];
  assign out_en_c  = ctl[2][PIN_W-1:0];
endmodule

// File: rtl/pario_regs_chk.sv
`timescale 1ns/1ps
module pario_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_we,
  input logic [3:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [6:0] pin_in_a,
  input logic [6:0] out_en_a,
  input logic       upd_valid,
  input logic [7:0] upd_data
);
  a_r4_strobe_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr >= 4'h1 && bus_addr <= 4'h3)
    |=> (upd_valid && upd_data == $past(bus_wdata)));

  a_r5_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $past(bus_sel && bus_we));

  a_r2_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_sel && bus_we && bus_addr == 4'h4) |-> $stable(out_en_a));

  a_r3_input_bit_from_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == 4'h1 && !out_en_a[0])
    |-> bus_rdata[0] == pin_in_a[0]);

  a_r9_reserved_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && (bus_addr == 4'h8 || bus_addr == 4'hB || bus_addr == 4'hE))
    |-> bus_rdata == 8'h00);
endmodule

bind pario_regs pario_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_in_a(pin_in_a), .out_en_a(out_en_a), .upd_valid(upd_valid),
  .upd_data(upd_data)
);

// File: tb/pario_regs_tb_top.sv
`timescale 1ns/1ps
module pario_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [6:0] pin_in_a = 7'h00, pin_in_b = 7'h00, pin_in_c = 7'h00;
  logic [2:0] ser_stat_a = 3'd0, ser_stat_b = 3'd0, ser_stat_c = 3'd0;
  logic [6:0] out_val_a, out_val_b, out_val_c, out_en_a, out_en_b, out_en_c;
  logic       upd_valid;
  logic [1:0] upd_port;
  logic [7:0] upd_data, upd_ctrl;

  int checks = 0;
  int fails  = 0;
  bit model_on = 1'b0;

  always #2.5 clk = ~clk;

  pario_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in_a(pin_in_a), .pin_in_b(pin_in_b), .pin_in_c(pin_in_c),
    .ser_stat_a(ser_stat_a), .ser_stat_b(ser_stat_b), .ser_stat_c(ser_stat_c),
    .out_val_a(out_val_a), .out_val_b(out_val_b), .out_val_c(out_val_c),
    .out_en_a(out_en_a), .out_en_b(out_en_b), .out_en_c(out_en_c),
    .upd_valid(upd_valid), .upd_port(upd_port), .upd_data(upd_data),
    .upd_ctrl(upd_ctrl)
  );

  // behavioural model: a flat byte map plus the expected strobe
  int m [16];
  int e_uv, e_up, e_ud, e_uc;

  function automatic int pin_of(int p);
    return p == 0 ? int'(pin_in_a) : p == 1 ? int'(pin_in_b) : int'(pin_in_c);
  endfunction
  function automatic int stat_of(int p);
    return p == 0 ? int'(ser_stat_a) : p == 1 ? int'(ser_stat_b) : int'(ser_stat_c);
  endfunction

  function automatic int exp_read(int a);
    int mask;
    if (a >= 1 && a <= 3) begin
      mask = 'h80 | m[a + 3];
      return (m[a] & mask) | (pin_of(a - 1) & ~mask & 'hFF);
    end
    if (a == 9 || a == 12 || a == 15) return m[a] | stat_of((a - 9) / 3);
    return m[a];
  endfunction

  function automatic string tag_of(int a);
    if (a == 0) return "R8";
    if (a >= 1 && a <= 3) return "R3";
    if (a >= 4 && a <= 6) return "R5";
    if (a == 7 || a == 10 || a == 13) return "R6";
    if (a == 9 || a == 12 || a == 15) return "R7";
    return "R9";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m[i] = 0;
      m[0] = 'hA0; m[7] = 'hFF; m[10] = 'hFF; m[13] = 'hFB;
      e_uv = 0; e_up = 0; e_ud = 0; e_uc = 0;
    end else begin
      int a, w;
      a = int'(bus_addr); w = int'(bus_wdata);
      e_uv = 0;
      if (bus_sel && bus_we) begin
        if (a >= 1 && a <= 3) begin
          e_uv = 1; e_up = a - 1; e_ud = w; e_uc = m[a + 3]; m[a] = w;
        end else if (a >= 4 && a <= 6) begin
          if (w != m[a]) begin e_uv = 1; e_up = a - 4; e_ud = m[a - 3]; e_uc = w; end
          m[a] = w;
        end else if (a == 7 || a == 10 || a == 13) m[a] = w;
        else if (a == 9 || a == 12 || a == 15) m[a] = w & 'hF8;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    if (bus_sel && !bus_we)
      check({tag_of(int'(bus_addr)), "/R10 read"}, int'(bus_rdata), exp_read(int'(bus_addr)));
    check("R2 out_val_a", int'(out_val_a), m[1] & 'h7F);
    check("R2 out_val_b", int'(out_val_b), m[2] & 'h7F);
    check("R2 out_val_c", int'(out_val_c), m[3] & 'h7F);
    check("R2 out_en_a", int'(out_en_a), m[4] & 'h7F);
    check("R2 out_en_b", int'(out_en_b), m[5] & 'h7F);
    check("R2 out_en_c", int'(out_en_c), m[6] & 'h7F);
    check("R4/R5 upd_valid", int'(upd_valid), e_uv);
    if (e_uv != 0) begin
      check("R4 upd_port", int'(upd_port), e_up);
      check("R4 upd_data", int'(upd_data), e_ud);
      check("R5 upd_ctrl", int'(upd_ctrl), e_uc);
    end
  endtask

  task automatic step(bit s, bit w, int a, int d);
    @(negedge clk);
    if (model_on) compare_all();
    bus_sel = s; bus_we = w; bus_addr = 4'(a); bus_wdata = 8'(d);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int rst_exp [16];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values through reads against fixed constants
    for (int i = 0; i < 16; i++) rst_exp[i] = 0;
    rst_exp[0] = 'hA0; rst_exp[7] = 'hFF; rst_exp[10] = 'hFF; rst_exp[13] = 'hFB;
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 4'(a);
      #1 check("R1 reset value", int'(bus_rdata), rst_exp[a]);
    end
    model_on = 1'b1;
    // R8/R9: writes to read-only offsets
    step(1, 1, 0, 'h00); step(1, 1, 8, 'h5A); step(1, 1, 11, 'hFF); step(1, 1, 14, 'h33);
    step(1, 0, 0, 0); step(1, 0, 8, 0); step(1, 0, 11, 0); step(1, 0, 14, 0);
    // R3: all inputs, then all outputs, then mixed
    pin_in_a = 7'h55;
    step(1, 1, 1, 'hAA); step(1, 0, 1, 0);
    step(1, 1, 4, 'h7F); step(1, 0, 1, 0);
    step(1, 1, 4, 'h0F); step(1, 0, 1, 0);
    // R5: same-value direction write gives no strobe
    step(1, 1, 4, 'h0F); step(0, 0, 0, 0); step(1, 1, 5, 'h00); step(0, 0, 0, 0);
    // R7: serial control masking and status bits
    ser_stat_b = 3'b101;
    step(1, 1, 12, 'hFF); step(1, 0, 12, 0); step(1, 1, 12, 'h47); step(1, 0, 12, 0);
    // R6: transmit registers
    step(1, 1, 13, 'h12); step(1, 0, 13, 0); step(1, 1, 7, 'h00); step(1, 0, 7, 0);
    // random traffic
    for (int n = 0; n < 6000; n++) begin
      int a, r;
      pin_in_a = 7'($urandom); pin_in_b = 7'($urandom); pin_in_c = 7'($urandom);
      ser_stat_a = 3'($urandom); ser_stat_b = 3'($urandom); ser_stat_c = 3'($urandom);
      a = $urandom_range(0, 15);
      r = $urandom_range(0, 9);
      if (a >= 4 && a <= 6 && r < 3) step(1, 1, a, m[a]);
      else step(r != 0, r > 5, a, $urandom_range(0, 255));
    end
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule